// File: doc/BRIEF.md
# Touch Sensor Mode Sequencer

This block is the control state machine that sits above a capacitive touch measurement front end. It walks the front end through power-up settling with a calibration pass, a low-power sleep phase that opens short sampling windows at a fixed interval, and a full operating phase in which the keys are scanned and reported. A quiet spell of fixed length sends it through a recalibration pass and back to sleep. An optional key-hold limit sends it back to the full power-up state when a key appears stuck on.

All timing is counted in ticks of an external slow timebase strobe, nominally 1 kHz. Every duration is a parameter, so a bench can shrink the whole schedule to a few dozen ticks. Three strap inputs choose the sleep sampling interval, the sample window length and whether the key-hold limit applies. They are captured while reset is held.

The outputs are a calibrate level, a sample-window level, a scan enable, the gated key vector and the current state code. The front end reports activity through one any-key input.

Top module: `touch_mode_seq`

## Requirements
- R1: After reset the state is INIT_CAL, `cal_o` is 1 and `key_o` is all zero. After CAL_TICKS ticks the state becomes SLEEP, and INIT_CAL leads to no other state.
- R2: `state_o` carries the state code: INIT_CAL=0, SLEEP=1, SAMPLE=2, OPERATE=3, RECAL=4.
- R3: In sleep, a sample window begins once every period. The period is SLOW_PERIOD ticks when `strap_rate_slow` is 1 and FAST_PERIOD ticks when it is 0. The SLEEP part of each period lasts the period minus the window length.
- R4: The window (state SAMPLE, `sample_o`=1) lasts LONG_WIN ticks when `strap_win_long` is 1 and SHORT_WIN ticks when it is 0. Without a detection the state then returns to SLEEP.
- R5: `key_det`=1 in SAMPLE moves the state to OPERATE on the next clock, where `scan_en_o` is 1.
- R6: `key_det` in SLEEP does not change the state. SLEEP leads only to SAMPLE or RECAL.
- R7: IDLE_TICKS consecutive ticks with `key_det`=0 in SLEEP, SAMPLE or OPERATE move the state to RECAL. Any cycle with `key_det`=1 restarts that count.
- R8: RECAL holds `cal_o`=1 for RECAL_TICKS ticks and then moves to SLEEP.
- R9: With `strap_hold_unlimited`=0, `key_det` held for KEYON_TICKS ticks in OPERATE moves the state to INIT_CAL with `key_o` zero. The hold count clears whenever `key_det` is 0.
- R10: With `strap_hold_unlimited`=1, OPERATE never moves to INIT_CAL, however long a key is held.
- R11: `key_o` equals `key_i` in OPERATE and is all zero in every other state.
- R12: The straps are sampled only while `rst_n` is 0. Changes to them after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while it is low |
| tick | input | 1 | One-cycle timebase strobe |
| strap_rate_slow | input | 1 | 1: slow sleep sampling interval, 0: fast |
| strap_win_long | input | 1 | 1: long sample window, 0: short |
| strap_hold_unlimited | input | 1 | 1: no key-hold limit, 0: limit active |
| key_det | input | 1 | Any-key-detected indication from the front end |
| key_i | input | NKEYS | Raw key states from the front end |
| cal_o | output | 1 | Calibration pass in progress |
| sample_o | output | 1 | Sleep sample window open |
| scan_en_o | output | 1 | Key scanning enabled |
| key_o | output | NKEYS | Key states, gated to OPERATE |
| state_o | output | 3 | Current state code |

## Verification
The bench builds the block with a 10-tick settle, a 12 or 6 tick sleep interval, a 4 or 2 tick window, a 40-tick quiet limit, a 5-tick recalibration and a 20-tick hold limit. At these values every transition is reached within a few dozen ticks: several full sample periods under each strap combination, the quiet limit landing mid-gap, and the key-hold limit firing or being ignored. Because the quiet limit is not a multiple of either interval, a delayed restart of the quiet count shows up as a misplaced RECAL entry.

// File: rtl/tms_pkg.sv
package tms_pkg;

   typedef enum logic [2:0] {
      ST_INIT_CAL = 3'd0,
      ST_SLEEP    = 3'd1,
      ST_SAMPLE   = 3'd2,
      ST_OPERATE  = 3'd3,
      ST_RECAL    = 3'd4
   } tms_state_e;

   function automatic int tms_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tms_straps.sv
module tms_straps (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_slow_i,
   input  logic win_long_i,
   input  logic hold_unl_i,
   output logic rate_slow_o,
   output logic win_long_o,
   output logic hold_unl_o
);

   logic [2:0] straps_q;

   // Capture continuously while reset is asserted, freeze afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) straps_q <= {hold_unl_i, win_long_i, rate_slow_i};
   end

   assign rate_slow_o = straps_q[0];
   assign win_long_o  = straps_q[1];
   assign hold_unl_o  = straps_q[2];

   AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(straps_q)); // R12

endmodule

// File: rtl/tms_tick_counter.sv
module tms_tick_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic         arm,
   input  logic [W-1:0] limit,
   output logic         hit
);

   if (W < 1) begin : g_bad_width
      $error("tms_tick_counter: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
   end

   // Fires on the tick that completes the limit
   assign hit = tick && arm && (cnt_q == limit - 1'b1);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= limit); // R7

endmodule

// File: rtl/tms_fsm.sv
module tms_fsm
   import tms_pkg::*;
#(
   parameter int CNT_W       = 17,
   parameter int CAL_TICKS   = 500,
   parameter int SLOW_PERIOD = 125,
   parameter int FAST_PERIOD = 16,
   parameter int LONG_WIN    = 4,
   parameter int SHORT_WIN   = 2,
   parameter int IDLE_TICKS  = 4000,
   parameter int RECAL_TICKS = 100,
   parameter int KEYON_TICKS = 80000,
   parameter bit KEYON_EN    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       key_det,
   input  logic       rate_slow,
   input  logic       win_long,
   input  logic       hold_unl,
   output logic [2:0] state_o,
   output logic       cal_o,
   output logic       sample_o,
   output logic       scan_o
);

   tms_state_e state_q, state_nxt;
   logic       ph_hit, idle_hit, keyon_hit;
   logic       ph_clr, idle_clr;
   logic [CNT_W-1:0] ph_limit, win_len, period_len;

   assign win_len    = win_long  ? CNT_W'(LONG_WIN)    : CNT_W'(SHORT_WIN);
   assign period_len = rate_slow ? CNT_W'(SLOW_PERIOD) : CNT_W'(FAST_PERIOD);

   always_comb begin
      case (state_q)
         ST_INIT_CAL: ph_limit = CNT_W'(CAL_TICKS);
         ST_SLEEP:    ph_limit = period_len - win_len;
         ST_SAMPLE:   ph_limit = win_len;
         ST_RECAL:    ph_limit = CNT_W'(RECAL_TICKS);
         default:     ph_limit = '1;
      endcase
   end

   // Phase timer restarts on every state entry and idles in OPERATE
   assign ph_clr = (state_nxt != state_q) || (state_q == ST_OPERATE);

   tms_tick_counter #(.W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .clr(ph_clr), .tick(tick), .arm(1'b1),
      .limit(ph_limit), .hit(ph_hit)
   );

   // Quiet timer: any key activity or a calibration pass restarts it
   assign idle_clr = key_det || (state_q == ST_INIT_CAL) || (state_q == ST_RECAL);

   tms_tick_counter #(.W(CNT_W)) u_idle (
      .clk(clk), .rst_n(rst_n), .clr(idle_clr), .tick(tick), .arm(!key_det),
      .limit(CNT_W'(IDLE_TICKS)), .hit(idle_hit)
   );

   if (KEYON_EN) begin : g_keyon
      logic keyon_clr;
      assign keyon_clr = !key_det || (state_q != ST_OPERATE) || hold_unl;
      tms_tick_counter #(.W(CNT_W)) u_keyon (
         .clk(clk), .rst_n(rst_n), .clr(keyon_clr), .tick(tick), .arm(key_det),
         .limit(CNT_W'(KEYON_TICKS)), .hit(keyon_hit)
      );
   end else begin : g_no_keyon
      assign keyon_hit = 1'b0;
   end

   always_comb begin
      state_nxt = state_q;
      case (state_q)
         ST_INIT_CAL: if (ph_hit) state_nxt = ST_SLEEP;
         ST_SLEEP: begin
            if (idle_hit)    state_nxt = ST_RECAL;
            else if (ph_hit) state_nxt = ST_SAMPLE;
         end
         ST_SAMPLE: begin
            if (key_det)       state_nxt = ST_OPERATE;
            else if (idle_hit) state_nxt = ST_RECAL;
            else if (ph_hit)   state_nxt = ST_SLEEP;
         end
         ST_OPERATE: begin
            if (keyon_hit && !hold_unl) state_nxt = ST_INIT_CAL;
            else if (idle_hit)          state_nxt = ST_RECAL;
         end
         ST_RECAL: if (ph_hit) state_nxt = ST_SLEEP;
         default: state_nxt = ST_INIT_CAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_INIT_CAL;
      else        state_q <= state_nxt;
   end

   assign state_o  = state_q;
   assign cal_o    = (state_q == ST_INIT_CAL) || (state_q == ST_RECAL);
   assign sample_o = (state_q == ST_SAMPLE);
   assign scan_o   = (state_q == ST_OPERATE);

   AST_INIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_INIT_CAL |=> state_q inside {ST_INIT_CAL, ST_SLEEP}); // R1
   AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_SLEEP |=> state_q inside {ST_SLEEP, ST_SAMPLE, ST_RECAL}); // R6
   AST_WAKE_ON_DET: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_SAMPLE && key_det |=> state_q == ST_OPERATE); // R5
   AST_RECAL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_RECAL |=> state_q inside {ST_RECAL, ST_SLEEP}); // R8
   AST_HOLD_UNLIMITED: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_OPERATE && hold_unl |=> state_q != ST_INIT_CAL); // R10

endmodule

// File: rtl/touch_mode_seq.sv
module touch_mode_seq
   import tms_pkg::*;
#(
   parameter int NKEYS       = 8,
   parameter int CAL_TICKS   = 500,
   parameter int SLOW_PERIOD = 125,
   parameter int FAST_PERIOD = 16,
   parameter int LONG_WIN    = 4,
   parameter int SHORT_WIN   = 2,
   parameter int IDLE_TICKS  = 4000,
   parameter int RECAL_TICKS = 100,
   parameter int KEYON_TICKS = 80000,
   parameter bit KEYON_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             strap_rate_slow,
   input  logic             strap_win_long,
   input  logic             strap_hold_unlimited,
   input  logic             key_det,
   input  logic [NKEYS-1:0] key_i,
   output logic             cal_o,
   output logic             sample_o,
   output logic             scan_en_o,
   output logic [NKEYS-1:0] key_o,
   output logic [2:0]       state_o
);

   localparam int LONGEST = tms_max(tms_max(tms_max(CAL_TICKS, SLOW_PERIOD),
                                            tms_max(IDLE_TICKS, RECAL_TICKS)),
                                    tms_max(KEYON_TICKS, FAST_PERIOD));
   localparam int CNT_W   = $clog2(LONGEST + 1);

   if (NKEYS < 1) begin : g_bad_keys
      $error("touch_mode_seq: NKEYS must be at least 1");
   end
   if (SHORT_WIN < 1 || LONG_WIN < SHORT_WIN) begin : g_bad_win
      $error("touch_mode_seq: windows need 1 <= SHORT_WIN <= LONG_WIN");
   end
   if (FAST_PERIOD <= LONG_WIN || SLOW_PERIOD < FAST_PERIOD) begin : g_bad_period
      $error("touch_mode_seq: periods must exceed the longest window");
   end
   if (CAL_TICKS < 1 || RECAL_TICKS < 1 || IDLE_TICKS < 1 || KEYON_TICKS < 1) begin : g_bad_dur
      $error("touch_mode_seq: durations must be at least one tick");
   end

   logic rate_slow, win_long, hold_unl, scan_en;

   tms_straps u_straps (
      .clk(clk), .rst_n(rst_n),
      .rate_slow_i(strap_rate_slow), .win_long_i(strap_win_long),
      .hold_unl_i(strap_hold_unlimited),
      .rate_slow_o(rate_slow), .win_long_o(win_long), .hold_unl_o(hold_unl)
   );

   tms_fsm #(
      .CNT_W(CNT_W), .CAL_TICKS(CAL_TICKS), .SLOW_PERIOD(SLOW_PERIOD),
      .FAST_PERIOD(FAST_PERIOD), .LONG_WIN(LONG_WIN), .SHORT_WIN(SHORT_WIN),
      .IDLE_TICKS(IDLE_TICKS), .RECAL_TICKS(RECAL_TICKS),
      .KEYON_TICKS(KEYON_TICKS), .KEYON_EN(KEYON_EN)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .key_det(key_det),
      .rate_slow(rate_slow), .win_long(win_long), .hold_unl(hold_unl),
      .state_o(state_o), .cal_o(cal_o), .sample_o(sample_o), .scan_o(scan_en)
   );

   assign scan_en_o = scan_en;

   for (genvar k = 0; k < NKEYS; k++) begin : g_gate
      assign key_o[k] = key_i[k] & scan_en;
   end

   AST_KEY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      key_o != '0 |-> state_o == 3'(ST_OPERATE)); // R11

endmodule

// File: tb/touch_mode_seq_test.sv
`timescale 1ns/1ps
module touch_mode_seq_test;

   localparam int NK = 8;
   localparam int S_INIT = 0, S_SLEEP = 1, S_SAMPLE = 2, S_OPER = 3, S_RECAL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic strap_rate_slow = 1'b1, strap_win_long = 1'b1, strap_hold_unlimited = 1'b1;
   logic key_det = 1'b0;
   logic [NK-1:0] key_i = '0;
   logic cal_o, sample_o, scan_en_o;
   logic [NK-1:0] key_o;
   logic [2:0] state_o;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   touch_mode_seq #(
      .NKEYS(NK), .CAL_TICKS(10), .SLOW_PERIOD(12), .FAST_PERIOD(6),
      .LONG_WIN(4), .SHORT_WIN(2), .IDLE_TICKS(40), .RECAL_TICKS(5),
      .KEYON_TICKS(20), .KEYON_EN(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .strap_rate_slow(strap_rate_slow), .strap_win_long(strap_win_long),
      .strap_hold_unlimited(strap_hold_unlimited),
      .key_det(key_det), .key_i(key_i),
      .cal_o(cal_o), .sample_o(sample_o), .scan_en_o(scan_en_o),
      .key_o(key_o), .state_o(state_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   // Reset with the given straps, check the settle phase, return at SLEEP entry
   task automatic do_reset(input logic rs, input logic wl, input logic hu);
      @(negedge clk);
      rst_n = 1'b0; key_det = 1'b0; key_i = '1; tick = 1'b0;
      strap_rate_slow = rs; strap_win_long = wl; strap_hold_unlimited = hu;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "state after reset", state_o, S_INIT);
      check("R1", "cal after reset", cal_o, 1);
      check("R11", "key_o in INIT_CAL", key_o, 0);
      ticks(9);
      check("R1", "still settling", state_o, S_INIT);
      ticks(1);
      check("R2", "SLEEP code after settle", state_o, S_SLEEP);
      check("R1", "cal cleared", cal_o, 0);
   endtask

   task automatic t_rates;
      do_reset(1'b0, 1'b0, 1'b1);        // fast, short: gap 4, window 2
      ticks(3);
      check("R3", "fast gap not over", state_o, S_SLEEP);
      ticks(1);
      check("R3", "fast gap over", state_o, S_SAMPLE);
      check("R4", "sample_o in window", sample_o, 1);
      ticks(1);
      check("R4", "short window mid", state_o, S_SAMPLE);
      ticks(1);
      check("R4", "short window end", state_o, S_SLEEP);
      ticks(4);
      check("R3", "next fast window", state_o, S_SAMPLE);
      do_reset(1'b1, 1'b1, 1'b1);        // slow, long: gap 8, window 4
      ticks(7);
      check("R3", "slow gap not over", state_o, S_SLEEP);
      check("R4", "sample_o low in sleep", sample_o, 0);
      ticks(1);
      check("R3", "slow gap over", state_o, S_SAMPLE);
      ticks(3);
      check("R4", "long window mid", state_o, S_SAMPLE);
      ticks(1);
      check("R4", "long window end", state_o, S_SLEEP);
      do_reset(1'b0, 1'b1, 1'b1);        // fast, long: gap 2, window 4
      ticks(2);
      check("R3", "fast long gap", state_o, S_SAMPLE);
      ticks(4);
      check("R4", "fast long window end", state_o, S_SLEEP);
   endtask

   task automatic t_idle_recal;
      do_reset(1'b1, 1'b1, 1'b1);
      ticks(39);
      check("R7", "quiet limit not reached", state_o, S_SLEEP);
      ticks(1);
      check("R7", "quiet limit reached", state_o, S_RECAL);
      check("R8", "cal in RECAL", cal_o, 1);
      ticks(4);
      check("R8", "recal mid", state_o, S_RECAL);
      ticks(1);
      check("R8", "recal done", state_o, S_SLEEP);
   endtask

   task automatic t_sleep_ignore;
      do_reset(1'b1, 1'b1, 1'b1);
      @(negedge clk); key_det = 1'b1; key_i = 8'hFF;
      ticks(3);
      check("R6", "key_det in SLEEP ignored", state_o, S_SLEEP);
      check("R11", "key_o gated in SLEEP", key_o, 0);
      key_det = 1'b0;
      ticks(37);
      check("R7", "quiet count restarted", state_o, S_SLEEP);
      ticks(3);
      check("R7", "restarted count expires", state_o, S_RECAL);
   endtask

   task automatic t_operate;
      do_reset(1'b1, 1'b1, 1'b1);
      ticks(8);
      check("R3", "window before wake", state_o, S_SAMPLE);
      @(negedge clk); key_det = 1'b1; key_i = 8'hA5;
      @(negedge clk);
      check("R5", "wake to OPERATE", state_o, S_OPER);
      check("R5", "scan enabled", scan_en_o, 1);
      check("R11", "key_o passes", key_o, 8'hA5);
      ticks(30);
      check("R10", "unlimited hold", state_o, S_OPER);
      key_det = 1'b0;
      ticks(39);
      check("R7", "operate quiet not reached", state_o, S_OPER);
      ticks(1);
      check("R7", "operate quiet reached", state_o, S_RECAL);
      check("R11", "key_o gated in RECAL", key_o, 0);
      ticks(5);
      check("R8", "back to SLEEP", state_o, S_SLEEP);
   endtask

   task automatic t_keyon;
      do_reset(1'b1, 1'b1, 1'b0);
      ticks(8);
      @(negedge clk); key_det = 1'b1; key_i = 8'h3C;
      @(negedge clk);
      check("R5", "wake before hold", state_o, S_OPER);
      ticks(19);
      check("R9", "hold limit not reached", state_o, S_OPER);
      ticks(1);
      check("R9", "hold limit forces INIT_CAL", state_o, S_INIT);
      check("R9", "key_o inactive", key_o, 0);
      check("R9", "cal after hold limit", cal_o, 1);
      key_det = 1'b0;
      ticks(10);
      check("R1", "settle after hold limit", state_o, S_SLEEP);
   endtask

   task automatic t_strap_latch;
      do_reset(1'b1, 1'b1, 1'b1);
      strap_rate_slow = 1'b0; strap_win_long = 1'b0;
      ticks(4);
      check("R12", "rate strap change ignored", state_o, S_SLEEP);
      ticks(4);
      check("R12", "latched slow interval", state_o, S_SAMPLE);
      ticks(2);
      check("R12", "win strap change ignored", state_o, S_SAMPLE);
      ticks(2);
      check("R12", "latched long window", state_o, S_SLEEP);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      t_rates();
      t_idle_recal();
      t_sleep_ignore();
      t_operate();
      t_keyon();
      t_strap_latch();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule